// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command front end and write sequencer for the protection bits of a parallel NOR-style flash. Each array block has one lock bit, and one permanent lock bit sits over all of them. A host writes command bytes with an address. A single-cycle command selects the read mode or clears the error flags. The lock operations use a two-cycle sequence: a setup byte, then a confirm byte. An operation that is accepted runs for a fixed number of clock cycles. During that time the ready output is low, and then the result is committed.

Reads are combinational. In array mode the block passes the array's data through. In status mode it returns an 8-bit status register, zero-extended to the data width. The block refuses a lock change in three cases: the programming voltage is not valid, the permanent lock is set, or the write-protect pin forbids it. Each cause of failure sets its own status flag, and the flags stay set until the host clears them.

The write path is a valid/ready channel. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole busy period. While it is low, the host must hold its command and address steady until the write is taken. The read path, `rdy`, the protection inputs and the lock outputs are plain level signals.

Top module: `lockcmd_ctrl`

## Requirements
- R1: The byte 0x60 starts a lock sequence, and the next accepted write is its confirm. Confirm 0x01 sets the lock bit of the block given by the top BLK_W address bits. Confirm 0xF1 sets the permanent lock and ignores the address. Confirm 0xD0 clears every block lock bit in a single commit.
- R2: If the write after 0x60 is any byte other than 0x01, 0xF1 or 0xD0, the sequence is invalid. It sets status bit 4 and status bit 5 in the next cycle, leaves all lock bits unchanged, and never lowers `rdy`.
- R3: Status byte layout: bit 7 is ready (1 = idle), bit 5 is the clear error, bit 4 is the set error, bit 3 is the voltage error, and bit 1 is the protection error. Bits 6, 2 and 0 read 0. In status mode, `rd_data` carries this byte in bits 7:0 with zeros above.
- R4: When a valid confirm is taken at clock edge k, `rdy`, status bit 7 and `wr_ready` are low from just after edge k until edge k+BUSY_CYC. The lock result and any error flags become visible at that edge.
- R5: The block enters status mode on 0x60, on any confirm or invalid second byte, and on 0x70. It returns to array mode only on 0xFF, where `rd_data` equals `arr_rdata`. The 0x50 command clears all error flags and does not change the mode.
- R6: While the permanent lock is set, a set-block confirm fails with bits 1 and 4, a clear confirm fails with bits 1 and 5, and no block lock bit changes.
- R7: The permanent lock bit never returns to 0 except through reset.
- R8: If `prog_v_ok` is low when a confirm is taken, the operation fails and no lock changes. A set (block or permanent) reports bits 3 and 4, and a clear reports bits 3 and 5. This check takes priority over the protection checks.
- R9: If `wprot_n` is low when a permanent-lock confirm is taken, the operation fails with bits 1 and 4, and the permanent lock stays 0.
- R10: Error flags accumulate and stay set until 0x50. A single-cycle byte other than 0x60, 0x70, 0x50 and 0xFF has no effect on mode, flags or locks.
- R11: After reset all lock bits are 0, the error flags are 0, the read mode is array, and `rdy` and `wr_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host presents a write |
| wr_ready | output | 1 | Write accepted on this edge when high; low while busy |
| wr_cmd | input | 8 | Command byte |
| wr_addr | input | ADDR_W | Write address; top BLK_W bits select a block |
| arr_rdata | input | DATA_W | Array read data, passed through in array mode |
| rd_data | output | DATA_W | Read data (array data or status byte) |
| rdy | output | 1 | High when idle, low during an operation |
| wprot_n | input | 1 | Write-protect, low forbids setting the permanent lock |
| prog_v_ok | input | 1 | Programming voltage is valid |
| blk_lock | output | NBLK | Current block lock bits |
| perm_lock | output | 1 | Current permanent lock bit |

## Verification
The bench builds the block with eight blocks, a 12-bit address and a busy period of three cycles. The short busy period makes it cheap to check the exact cycle where `rdy` falls and the cycle where it rises for every lock operation. With only eight blocks, the random sequences often set, clear and set again the same block. The permanent lock is left to a directed phase at the end, so the random phase explores both locks set and locks cleared before everything freezes.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  localparam logic [7:0] CMD_SETUP     = 8'h60;
  localparam logic [7:0] CMD_CONF_BLK  = 8'h01;
  localparam logic [7:0] CMD_CONF_PERM = 8'hF1;
  localparam logic [7:0] CMD_CONF_CLR  = 8'hD0;
  localparam logic [7:0] CMD_RD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_RD_ARR    = 8'hFF;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SETUP,
    OP_SET_BLK,
    OP_SET_PERM,
    OP_CLR_ALL,
    OP_BAD_SEQ,
    OP_RD_STAT,
    OP_CLR_STAT,
    OP_RD_ARR
  } op_e;

  typedef struct packed {
    logic clr;   // status bit 5
    logic set;   // status bit 4
    logic volt;  // status bit 3
    logic prot;  // status bit 1
  } err_t;

  function automatic logic is_lock_op(input op_e op);
    return (op == OP_SET_BLK) || (op == OP_SET_PERM) || (op == OP_CLR_ALL);
  endfunction
endpackage

// File: rtl/lkc_decode.sv
module lkc_decode
  import lkc_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [7:0]       cmd,
  input  logic [BLK_W-1:0] blk_addr,
  output op_e              op,
  output logic [BLK_W-1:0] op_blk
);
  logic pend_q, pend_d;

  always_comb begin
    op     = OP_NONE;
    pend_d = pend_q;
    if (fire) begin
      if (pend_q) begin
        pend_d = 1'b0;
        unique case (cmd)
          CMD_CONF_BLK:  op = OP_SET_BLK;
          CMD_CONF_PERM: op = OP_SET_PERM;
          CMD_CONF_CLR:  op = OP_CLR_ALL;
          default:       op = OP_BAD_SEQ;
        endcase
      end else begin
        unique case (cmd)
          CMD_SETUP:    begin op = OP_SETUP; pend_d = 1'b1; end
          CMD_RD_STAT:  op = OP_RD_STAT;
          CMD_CLR_STAT: op = OP_CLR_STAT;
          CMD_RD_ARR:   op = OP_RD_ARR;
          default:      op = OP_NONE;
        endcase
      end
    end
  end

  assign op_blk = blk_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R1
  second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pend_q) |-> (op != OP_NONE && op != OP_SETUP && op != OP_RD_STAT));
endmodule

// File: rtl/lkc_wsm.sv
module lkc_wsm
  import lkc_pkg::*;
#(
  parameter int BLK_W    = 3,
  parameter int BUSY_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [BLK_W-1:0] op_blk,
  input  logic             prog_v_ok,
  input  logic             wprot_n,
  input  logic             perm_lock,
  output logic             busy,
  output logic             done,
  output err_t             done_err,
  output logic             do_set_blk,
  output logic             do_set_perm,
  output logic             do_clr_all,
  output logic [BLK_W-1:0] do_blk
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  op_e              kind_q;
  logic [BLK_W-1:0] blk_q;
  err_t             err_q, err_d;

  always_comb begin
    err_d = '0;
    if (!prog_v_ok) begin
      err_d.volt = 1'b1;
      if (op == OP_CLR_ALL) err_d.clr = 1'b1;
      else                  err_d.set = 1'b1;
    end else if (op == OP_SET_PERM) begin
      if (!wprot_n) begin err_d.prot = 1'b1; err_d.set = 1'b1; end
    end else if (perm_lock) begin
      err_d.prot = 1'b1;
      if (op == OP_CLR_ALL) err_d.clr = 1'b1;
      else                  err_d.set = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= OP_NONE;
      blk_q  <= '0;
      err_q  <= '0;
    end else if (is_lock_op(op) && cnt_q == '0) begin
      cnt_q  <= CNT_W'(BUSY_CYC);
      kind_q <= op;
      blk_q  <= op_blk;
      err_q  <= err_d;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy        = (cnt_q != '0);
  assign done        = (cnt_q == CNT_W'(1));
  assign done_err    = err_q;
  assign do_set_blk  = done && err_q == '0 && kind_q == OP_SET_BLK;
  assign do_set_perm = done && err_q == '0 && kind_q == OP_SET_PERM;
  assign do_clr_all  = done && err_q == '0 && kind_q == OP_CLR_ALL;
  assign do_blk      = blk_q;

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !is_lock_op(op));
  // R4
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/lkc_locks.sv
module lkc_locks #(
  parameter int NBLK  = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_set_blk,
  input  logic             do_set_perm,
  input  logic             do_clr_all,
  input  logic [BLK_W-1:0] do_blk,
  output logic [NBLK-1:0]  blk_q,
  output logic             perm_q
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   blk_q[i] <= 1'b0;
      else if (do_clr_all)                          blk_q[i] <= 1'b0;
      else if (do_set_blk && do_blk == BLK_W'(i))   blk_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           perm_q <= 1'b0;
    else if (do_set_perm) perm_q <= 1'b1;
  end

  // R7
  perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  // R6
  blk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(blk_q));
  // R1
  one_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_set_blk |=> ($countones(blk_q & ~$past(blk_q)) <= 1));
endmodule

// File: rtl/lockcmd_ctrl.sv
module lockcmd_ctrl
  import lkc_pkg::*;
#(
  parameter int NBLK     = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy,
  input  logic              wprot_n,
  input  logic              prog_v_ok,
  output logic [NBLK-1:0]   blk_lock,
  output logic              perm_lock
);
  localparam int BLK_W = $clog2(NBLK);

  op_e              op;
  logic [BLK_W-1:0] op_blk, do_blk;
  logic             busy, done, do_set_blk, do_set_perm, do_clr_all;
  err_t             done_err, err_q;
  logic             stat_mode_q;
  logic [7:0]       sr;

  assign wr_ready = !busy;
  assign rdy      = !busy;

  lkc_decode #(.BLK_W(BLK_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (wr_valid && wr_ready),
    .cmd      (wr_cmd),
    .blk_addr (wr_addr[ADDR_W-1 -: BLK_W]),
    .op       (op),
    .op_blk   (op_blk)
  );

  lkc_wsm #(.BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) u_wsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .op_blk      (op_blk),
    .prog_v_ok   (prog_v_ok),
    .wprot_n     (wprot_n),
    .perm_lock   (perm_lock),
    .busy        (busy),
    .done        (done),
    .done_err    (done_err),
    .do_set_blk  (do_set_blk),
    .do_set_perm (do_set_perm),
    .do_clr_all  (do_clr_all),
    .do_blk      (do_blk)
  );

  lkc_locks #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_set_blk  (do_set_blk),
    .do_set_perm (do_set_perm),
    .do_clr_all  (do_clr_all),
    .do_blk      (do_blk),
    .blk_q       (blk_lock),
    .perm_q      (perm_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q       <= '0;
      stat_mode_q <= 1'b0;
    end else begin
      if (op == OP_CLR_STAT)     err_q <= '0;
      else if (op == OP_BAD_SEQ) err_q <= err_q | err_t'{clr: 1'b1, set: 1'b1, volt: 1'b0, prot: 1'b0};
      else if (done)             err_q <= err_q | done_err;

      if (op == OP_RD_ARR)
        stat_mode_q <= 1'b0;
      else if (op == OP_SETUP || op == OP_RD_STAT || op == OP_BAD_SEQ || is_lock_op(op))
        stat_mode_q <= 1'b1;
    end
  end

  assign sr      = {!busy, 1'b0, err_q.clr, err_q.set, err_q.volt, 1'b0, err_q.prot, 1'b0};
  assign rd_data = stat_mode_q ? {{(DATA_W-8){1'b0}}, sr} : arr_rdata;

  // R2
  bad_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BAD_SEQ) |=> (err_q.clr && err_q.set && $stable(blk_lock) && !busy));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_CLR_STAT) |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R4
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> !wr_ready);
endmodule

// File: tb/lockcmd_ctrl_bench.sv
`timescale 1ns/1ps
module lockcmd_ctrl_bench;
  localparam int NB = 8, AW = 12, DW = 16, BC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready, rdy, wprot_n = 1'b1, prog_v_ok = 1'b1, perm_lock;
  logic [7:0] wr_cmd = 8'h00;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] arr_rdata = 16'hA5C3, rd_data;
  logic [NB-1:0] blk_lock;

  int checks = 0, failures = 0;
  logic [NB-1:0] m_blk = '0;
  logic m_perm = 1'b0, m_stat = 1'b0;
  logic [7:0] m_err = 8'h00;

  always #2.5 clk = ~clk;

  lockcmd_ctrl #(.NBLK(NB), .ADDR_W(AW), .DATA_W(DW), .BUSY_CYC(BC)) u_lockcmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_cmd(wr_cmd),
    .wr_addr(wr_addr), .arr_rdata(arr_rdata), .rd_data(rd_data), .rdy(rdy),
    .wprot_n(wprot_n), .prog_v_ok(prog_v_ok), .blk_lock(blk_lock), .perm_lock(perm_lock));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 set block, 1 set permanent, 2 clear all
  function automatic logic [7:0] op_err(input int kind, input logic vok, input logic wpn, input logic perm);
    if (!vok) return (kind == 2) ? 8'h28 : 8'h18;
    if (kind == 1) return wpn ? 8'h00 : 8'h12;
    if (perm) return (kind == 2) ? 8'h22 : 8'h12;
    return 8'h00;
  endfunction

  function automatic logic [DW-1:0] exp_rd();
    return m_stat ? {8'h00, 8'h80 | m_err} : arr_rdata;
  endfunction

  task automatic check_state(input string tag);
    @(negedge clk);
    chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd()));
    chk({tag, " blk_lock"}, 32'(blk_lock), 32'(m_blk));
    chk({tag, " perm_lock"}, 32'(perm_lock), 32'(m_perm));
  endtask

  task automatic do_write(input logic [7:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_cmd = c; wr_addr = a;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic lock_op(input int kind, input logic [2:0] blk, input string tag);
    logic [7:0] e;
    logic [7:0] code;
    code = (kind == 0) ? 8'h01 : (kind == 1) ? 8'hF1 : 8'hD0;
    do_write(8'h60, AW'($urandom));
    m_stat = 1'b1;
    do_write(code, {blk, 9'($urandom)});
    e = op_err(kind, prog_v_ok, wprot_n, m_perm);
    @(negedge clk);
    chk("R4 rdy low after confirm", 32'(rdy), 0);
    chk("R4 wr_ready low while busy", 32'(wr_ready), 0);
    repeat (BC - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 rdy low at last busy cycle", 32'(rdy), 0);
    chk("R3 status bit7 busy", 32'(rd_data[7]), 0);
    m_err |= e;
    if (e == 8'h00) begin
      if (kind == 0) m_blk[blk] = 1'b1;
      else if (kind == 1) m_perm = 1'b1;
      else m_blk = '0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R4 rdy back after BUSY_CYC", 32'(rdy), 1);
    check_state(tag);
  endtask

  task automatic bad_seq(input logic [7:0] c, input string tag);
    do_write(8'h60, '0);
    do_write(c, AW'($urandom));
    m_stat = 1'b1;
    m_err |= 8'h30;
    @(negedge clk);
    chk("R2 no busy on invalid sequence", 32'(rdy), 1);
    check_state(tag);
  endtask

  task automatic simple(input logic [7:0] c, input string tag);
    do_write(c, AW'($urandom));
    if (c == 8'h70) m_stat = 1'b1;
    else if (c == 8'hFF) m_stat = 1'b0;
    else if (c == 8'h50) m_err = 8'h00;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R4 act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdy", 32'(rdy), 1);
    chk("R11 wr_ready", 32'(wr_ready), 1);
    check_state("R11 reset");

    simple(8'h70, "R3 idle status byte");
    lock_op(0, 3'd2, "R1 set block 2");
    lock_op(0, 3'd5, "R1 set block 5");
    lock_op(0, 3'd7, "R1 set block 7");
    lock_op(2, 3'd0, "R1 clear all");
    bad_seq(8'h33, "R2 invalid confirm");
    simple(8'h50, "R10 clear status keeps mode R5");
    simple(8'hFF, "R5 array mode");
    arr_rdata = 16'h1234;
    check_state("R5 array pass-through");
    simple(8'h20, "R10 unknown code ignored");
    prog_v_ok = 1'b0;
    lock_op(0, 3'd1, "R8 set with bad voltage");
    lock_op(2, 3'd1, "R8 clear with bad voltage");
    prog_v_ok = 1'b1;
    simple(8'h50, "R10 clear status");

    for (int i = 0; i < 150; i++) begin
      arr_rdata = 16'($urandom);
      prog_v_ok = ($urandom % 6) != 0;
      wprot_n = $urandom % 2;
      case ($urandom % 9)
        0, 1, 2: lock_op(0, 3'($urandom), "R1 random set block");
        3: lock_op(2, 3'($urandom), "R1 random clear");
        4: begin
          c = 8'($urandom);
          if (c == 8'h01 || c == 8'hF1 || c == 8'hD0) c = 8'h02;
          bad_seq(c, "R2 random invalid");
        end
        5: simple(8'h70, "R5 random read status");
        6: simple(8'h50, "R10 random clear status");
        7: simple(8'hFF, "R5 random read array");
        default: simple(8'h9A, "R10 random unknown code");
      endcase
    end

    prog_v_ok = 1'b1; wprot_n = 1'b1;
    simple(8'h50, "R10 clear before permanent phase");
    lock_op(0, 3'd1, "R1 set block 1");
    wprot_n = 1'b0;
    lock_op(1, 3'd0, "R9 permanent with write-protect");
    simple(8'h50, "R10 clear");
    prog_v_ok = 1'b0;
    lock_op(1, 3'd0, "R8 voltage priority over R9");
    prog_v_ok = 1'b1; wprot_n = 1'b1;
    simple(8'h50, "R10 clear");
    lock_op(1, 3'd6, "R1 set permanent");
    lock_op(0, 3'd4, "R6 set block blocked");
    simple(8'h50, "R10 clear");
    lock_op(2, 3'd0, "R6 clear blocked");
    lock_op(1, 3'd0, "R7 permanent set again");
    simple(8'hFF, "R7 permanent stays");
    simple(8'h50, "R7 permanent after clear status");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule